// File: doc/BRIEF.md
# Compare and Auto-Reload Interrupt Timer

This block sits on a 32-bit register bus and watches a free-running 64-bit count that an external system counter supplies on an input port. It raises one interrupt line. In compare mode, the line rises once the count has reached a programmable 64-bit compare value. Software can also see and set that compare value as a signed 32-bit "time remaining" relative to the current count.

In auto-reload mode, the block re-arms itself on its own. Each time the count reaches an internal target, it sets a sticky event flag and moves the target to the current count plus a 32-bit reload interval. While that mode is selected, the sticky flag drives the interrupt in place of the compare condition. Software clears the flag by writing zero to it.

The register map also holds a free 32-bit frequency word, a configuration word that advertises the auto-reload feature, and a block of read-only identification words. The comparisons are evaluated every clock. The interrupt output is registered.

Top module: `cmp_reload_timer`

## Requirements
- R1: After reset, every writable register reads 0: control, compare, reload, auto-reload control, frequency and auto-reload target. The interrupt output is 0.
- R2: The compare condition holds when the timer is enabled and the count, read as an unsigned 64-bit number, is greater than or equal to the 64-bit compare value. The compare value is at 0x20 (low word) and 0x24 (high word).
- R3: The control word at 0x2C has these bits. Bit 0 is the enable and bit 1 is the interrupt mask; both are read/write. Bit 2 is the live status; it is read-only, and a write to it is dropped.
- R4: A read of 0x28 returns bits [31:0] of (compare − count). A write to 0x28 sets compare to count plus the written word sign-extended to 64 bits.
- R5: The interrupt output is a register. At each clock it takes (NOT mask) AND status, computed from the state before that clock edge. It therefore follows a register change one cycle later.
- R6: The 64-bit auto-reload target (0x40 low, 0x44 high) is loaded with count + reload in two cases. The first is when the enable goes from 0 to 1 while auto-reload is selected. The second is when auto-reload selection (bit 0 of 0x4C) goes from 0 to 1 while the enable is set. The reload word is at 0x48.
- R7: When the timer is enabled, auto-reload is selected and the count is greater than or equal to the target, the block does two things on that clock edge. It sets the sticky flag (bit 1 of 0x4C) and reloads the target with count + reload.
- R8: A write to 0x4C stores bit 0 as the selection. A 0 in bit 1 clears the sticky flag; a 1 in bit 1 leaves it unchanged. Both bits read back. The write does not move the target unless the selection rises.
- R9: While auto-reload is selected, status equals the sticky flag and the compare condition is ignored. While the enable is 0, status is 0.
- R10: Reads of 0x00 and 0x04 return the low and high words of the count input. Writes to the count, the target, the configuration and the identification words have no effect.
- R11: The configuration word at 0x50 reads 1. Reads from unmapped or unaligned offsets return 0.
- R12: The identification words at 0xFD0 to 0xFFC, in address order, read 0x04, 0x00, 0x00, 0x00, 0xB7, 0xB0, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R13: The frequency word at 0x10 stores and returns all 32 bits. It has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pSel | input | 1 | Bus select |
| pEnable | input | 1 | Access phase of a transfer |
| pWrite | input | 1 | 1 for write, 0 for read |
| pAddr | input | 12 | Byte address |
| pWdata | input | 32 | Write data |
| pRdata | output | 32 | Read data, valid in the access phase |
| pReady | output | 1 | Always 1: no wait states |
| sysCount | input | 64 | Free-running count from the system counter |
| timerIrq | output | 1 | Registered interrupt |

## Verification
The bench builds the block with its default widths: a 64-bit count, a 32-bit data word and a 12-bit byte address. Because the bench drives the count directly instead of waiting for it to run, several edge cases come within reach in a few cycles. These include carries across bit 32 in the relative view, an unsigned compare at the 2^63 boundary, and equality at the top of the 64-bit range. The bench steps the count onto an auto-reload target to show the flag and the re-arm on exactly one edge. It also checks the one-cycle lag of the interrupt output against the status bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 64;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int ID_N   = 12;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_FREQ    = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI  = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_REL     = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_CTL     = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_AR_LO   = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_AR_HI   = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_RELOAD  = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_AR_CTL  = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_CFG     = 12'h050;

  // Write strobes from the register interface to the datapath
  typedef struct packed {
    logic              wrFreq;
    logic              wrCmpLo;
    logic              wrCmpHi;
    logic              wrRel;
    logic              wrCtl;
    logic              wrReload;
    logic              wrArCtl;
    logic [DATA_W-1:0] wdata;
  } tmr_strobe_t;

  // Architectural state seen by the read mux
  typedef struct packed {
    logic [CNT_W-1:0]  cmpVal;
    logic [CNT_W-1:0]  arTarget;
    logic [DATA_W-1:0] freq;
    logic [DATA_W-1:0] reload;
    logic              enable;
    logic              mask;
    logic              status;
    logic              arSel;
    logic              arFlag;
  } tmr_view_t;

  function automatic logic [7:0] idByte(input logic [3:0] idx);
    case (idx)
      4'd0:    idByte = 8'h04;
      4'd4:    idByte = 8'hB7;
      4'd5:    idByte = 8'hB0;
      4'd6:    idByte = 8'h0B;
      4'd8:    idByte = 8'h0D;
      4'd9:    idByte = 8'hF0;
      4'd10:   idByte = 8'h05;
      4'd11:   idByte = 8'hB1;
      default: idByte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
(
  input  logic                pSel,
  input  logic                pEnable,
  input  logic                pWrite,
  input  logic [ADDR_W-1:0]   pAddr,
  input  logic [DATA_W-1:0]   pWdata,
  input  logic [CNT_W-1:0]    sysCount,
  input  tmr_view_t           view,
  output tmr_strobe_t         strobe,
  output logic [DATA_W-1:0]   pRdata
);
  localparam int HI_LSB = CNT_W - DATA_W;

  logic wrAcc, rdAcc, idHit;
  logic [3:0] idIdx;
  logic [DATA_W-1:0] relView;

  assign wrAcc = pSel && pEnable && pWrite;
  assign rdAcc = pSel && pEnable && !pWrite;

  always_comb begin
    strobe          = '0;
    strobe.wdata    = pWdata;
    strobe.wrFreq   = wrAcc && (pAddr == OFS_FREQ);
    strobe.wrCmpLo  = wrAcc && (pAddr == OFS_CMP_LO);
    strobe.wrCmpHi  = wrAcc && (pAddr == OFS_CMP_HI);
    strobe.wrRel    = wrAcc && (pAddr == OFS_REL);
    strobe.wrCtl    = wrAcc && (pAddr == OFS_CTL);
    strobe.wrReload = wrAcc && (pAddr == OFS_RELOAD);
    strobe.wrArCtl  = wrAcc && (pAddr == OFS_AR_CTL);
  end

  // Identification block: aligned words from 0xFD0 to 0xFFC
  assign idIdx   = pAddr[5:2] - 4'd4;
  assign idHit   = (pAddr[ADDR_W-1:6] == '1) && (pAddr[5:2] >= 4'd4) && (pAddr[1:0] == 2'b00);
  assign relView = view.cmpVal[DATA_W-1:0] - sysCount[DATA_W-1:0];

  always_comb begin
    pRdata = '0;
    if (rdAcc) begin
      if (idHit) begin
        pRdata = {{(DATA_W-8){1'b0}}, idByte(idIdx)};
      end else begin
        case (pAddr)
          OFS_CNT_LO: pRdata = sysCount[DATA_W-1:0];
          OFS_CNT_HI: pRdata = sysCount[CNT_W-1:HI_LSB];
          OFS_FREQ:   pRdata = view.freq;
          OFS_CMP_LO: pRdata = view.cmpVal[DATA_W-1:0];
          OFS_CMP_HI: pRdata = view.cmpVal[CNT_W-1:HI_LSB];
          OFS_REL:    pRdata = relView;
          OFS_CTL:    pRdata = {{(DATA_W-3){1'b0}}, view.status, view.mask, view.enable};
          OFS_AR_LO:  pRdata = view.arTarget[DATA_W-1:0];
          OFS_AR_HI:  pRdata = view.arTarget[CNT_W-1:HI_LSB];
          OFS_RELOAD: pRdata = view.reload;
          OFS_AR_CTL: pRdata = {{(DATA_W-2){1'b0}}, view.arFlag, view.arSel};
          OFS_CFG:    pRdata = {{(DATA_W-4){1'b0}}, 4'd1};
          default:    pRdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strobe,
  input  logic [CNT_W-1:0] sysCount,
  output tmr_view_t        view,
  output logic             timerIrq
);
  localparam int EXT_W  = CNT_W - DATA_W;
  localparam int HI_LSB = CNT_W - DATA_W;

  logic [CNT_W-1:0]  cmpVal, arTarget, nextTarget, relCmp;
  logic [DATA_W-1:0] freq, reload;
  logic enable, mask, arSel, arFlag;
  logic cmpGe, arGe, status, armNow, fire, irqQ;

  assign cmpGe      = sysCount >= cmpVal;
  assign arGe       = sysCount >= arTarget;
  assign nextTarget = sysCount + {{EXT_W{1'b0}}, reload};
  assign relCmp     = sysCount + {{EXT_W{strobe.wdata[DATA_W-1]}}, strobe.wdata};
  assign status     = enable && (arSel ? arFlag : cmpGe);

  // Arm on a rising enable with selection set, or a rising selection with enable set
  assign armNow = (strobe.wrCtl   && strobe.wdata[0] && !enable && arSel) ||
                  (strobe.wrArCtl && strobe.wdata[0] && !arSel  && enable);
  assign fire   = enable && arSel && arGe && !armNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal   <= '0;
      arTarget <= '0;
      freq     <= '0;
      reload   <= '0;
      enable   <= 1'b0;
      mask     <= 1'b0;
      arSel    <= 1'b0;
      arFlag   <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      irqQ <= !mask && status;
      if (strobe.wrFreq)   freq   <= strobe.wdata;
      if (strobe.wrReload) reload <= strobe.wdata;
      if (strobe.wrCmpLo)  cmpVal[DATA_W-1:0]    <= strobe.wdata;
      if (strobe.wrCmpHi)  cmpVal[CNT_W-1:HI_LSB] <= strobe.wdata;
      if (strobe.wrRel)    cmpVal <= relCmp;
      if (strobe.wrCtl) begin
        enable <= strobe.wdata[0];
        mask   <= strobe.wdata[1];
      end
      if (strobe.wrArCtl) arSel <= strobe.wdata[0];
      if (armNow || fire) arTarget <= nextTarget;
      if (fire)
        arFlag <= 1'b1;
      else if (strobe.wrArCtl && !strobe.wdata[1])
        arFlag <= 1'b0;
    end
  end

  always_comb begin
    view          = '0;
    view.cmpVal   = cmpVal;
    view.arTarget = arTarget;
    view.freq     = freq;
    view.reload   = reload;
    view.enable   = enable;
    view.mask     = mask;
    view.status   = status;
    view.arSel    = arSel;
    view.arFlag   = arFlag;
  end

  assign timerIrq = irqQ;
endmodule

// File: rtl/cmp_reload_timer.sv
module cmp_reload_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWdata,
  output logic [DATA_W-1:0] pRdata,
  output logic              pReady,
  input  logic [CNT_W-1:0]  sysCount,
  output logic              timerIrq
);
  tmr_strobe_t strobe;
  tmr_view_t   view;

  assign pReady = 1'b1;

  tmr_regif u_regif (
    .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite), .pAddr(pAddr),
    .pWdata(pWdata), .sysCount(sysCount), .view(view),
    .strobe(strobe), .pRdata(pRdata)
  );

  tmr_core u_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sysCount(sysCount),
    .view(view), .timerIrq(timerIrq)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        pSel,
  input logic        pEnable,
  input logic        pWrite,
  input logic [11:0] pAddr,
  input logic [1:0]  ctlBits,
  input logic [31:0] pRdata,
  input logic [31:0] cntLo,
  input logic        timerIrq
);
  logic rdAcc, wrAcc;
  assign rdAcc = pSel && pEnable && !pWrite;
  assign wrAcc = pSel && pEnable && pWrite;

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && pAddr == 12'h030) |-> (pRdata == 32'h0));

  // R11
  cfg_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && pAddr == 12'h050) |-> (pRdata == 32'h1));

  // R10
  count_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && pAddr == 12'h000) |-> (pRdata == cntLo));

  // R5
  irq_follows_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && pAddr == 12'h02C) |=> (timerIrq == $past(pRdata[2] && !pRdata[1])));

  // R9
  off_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && pAddr == 12'h02C && !pRdata[0]) |-> !pRdata[2]);

  // R9
  quiet_after_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && pAddr == 12'h02C && (!ctlBits[0] || ctlBits[1])) |=> ##1 !timerIrq);
endmodule

bind cmp_reload_timer tmr_chk u_chk (
  .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
  .pAddr(pAddr), .ctlBits(pWdata[1:0]), .pRdata(pRdata),
  .cntLo(sysCount[31:0]), .timerIrq(timerIrq)
);

// File: tb/sim_cmp_reload_timer.sv
module sim_cmp_reload_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [11:0] pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic        pReady;
  logic [63:0] sysCount = '0;
  logic        timerIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [11:0] addr;
    string       tag;
  } item_t;
  item_t sbQ[$];

  always #2 clk = ~clk;

  cmp_reload_timer u0 (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .pReady(pReady),
    .sysCount(sysCount), .timerIrq(timerIrq)
  );

  // Monitor: pops an expected item for each read access phase
  always begin
    @(negedge clk);
    #1;
    if (pSel && pEnable && !pWrite) begin
      if (sbQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL scoreboard: read at %h with no expected item", pAddr);
      end else begin
        item_t it;
        it = sbQ.pop_front();
        nChecks++;
        if (pRdata !== it.exp || !pReady) begin
          nFails++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, pRdata, it.exp);
        end
      end
    end
  end

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); pSel = 1; pEnable = 0; pWrite = 1; pAddr = a; pWdata = d;
    @(negedge clk); pEnable = 1;
    @(negedge clk); pSel = 0; pEnable = 0; pWrite = 0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.addr = a; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk); pSel = 1; pEnable = 0; pWrite = 0; pAddr = a;
    @(negedge clk); pEnable = 1;
    @(negedge clk); pSel = 0; pEnable = 0;
  endtask

  task automatic setCount(input logic [63:0] v);
    @(negedge clk); sysCount = v;
  endtask

  task automatic irqNow(input logic e, input string tag);
    #1;
    nChecks++;
    if (timerIrq !== e) begin
      nFails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, timerIrq, e);
    end
  endtask

  task automatic irqSettled(input logic e, input string tag);
    repeat (2) @(negedge clk);
    irqNow(e, tag);
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [7:0] idTab [12];
    idTab = '{8'h04, 8'h00, 8'h00, 8'h00, 8'hB7, 8'hB0, 8'h0B, 8'h00,
              8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    irqNow(1'b0, "R1 irq");
    busRead(12'h02C, 32'h0, "R1 ctl");
    busRead(12'h020, 32'h0, "R1 cmp lo");
    busRead(12'h024, 32'h0, "R1 cmp hi");
    busRead(12'h048, 32'h0, "R1 reload");
    busRead(12'h04C, 32'h0, "R1 arctl");
    busRead(12'h010, 32'h0, "R1 freq");
    busRead(12'h040, 32'h0, "R1 target lo");

    // R13 frequency word
    busWrite(12'h010, 32'h0123_4567);
    busRead(12'h010, 32'h0123_4567, "R13 freq");

    // R11 config and unmapped
    busRead(12'h050, 32'h1, "R11 cfg");
    busRead(12'h030, 32'h0, "R11 unmapped 030");
    busRead(12'h054, 32'h0, "R11 unmapped 054");
    busRead(12'hFD2, 32'h0, "R11 unaligned id");

    // R12 identification words
    for (int i = 0; i < 12; i++)
      busRead(12'hFD0 + 12'(4 * i), {24'h0, idTab[i]}, "R12 id");

    // R10 count view and ignored writes
    setCount(64'h1234_5678_9ABC_DEF0);
    busRead(12'h000, 32'h9ABC_DEF0, "R10 count lo");
    busRead(12'h004, 32'h1234_5678, "R10 count hi");
    busWrite(12'h000, 32'hDEAD_BEEF);
    busRead(12'h000, 32'h9ABC_DEF0, "R10 count lo after write");
    busWrite(12'h050, 32'hF);
    busRead(12'h050, 32'h1, "R10 cfg after write");
    busWrite(12'hFD0, 32'hFF);
    busRead(12'hFD0, 32'h04, "R10 id after write");
    busWrite(12'h040, 32'h5);
    busRead(12'h040, 32'h0, "R10 target after write");

    // R3 control bits, status bit dropped on write
    busWrite(12'h024, 32'hFFFF_FFFF);
    busWrite(12'h02C, 32'h7);
    busRead(12'h02C, 32'h3, "R3 ctl status write dropped");
    irqSettled(1'b0, "R3 masked idle");

    // R2 unsigned compare at top of range
    setCount(64'hFFFF_FFFE_FFFF_FFFF);
    busRead(12'h02C, 32'h3, "R2 below cmp");
    setCount(64'hFFFF_FFFF_0000_0000);
    busRead(12'h02C, 32'h7, "R2 equal cmp");
    irqSettled(1'b0, "R2 masked");

    // R5 one-cycle lag on unmask
    busWrite(12'h02C, 32'h1);
    irqNow(1'b0, "R5 irq before lag");
    @(negedge clk);
    irqNow(1'b1, "R5 irq after lag");

    // R2 boundary at bit 63
    busWrite(12'h024, 32'h8000_0000);
    busWrite(12'h020, 32'h0);
    setCount(64'h7FFF_FFFF_FFFF_FFFF);
    busRead(12'h02C, 32'h1, "R2 just below 2^63");
    irqSettled(1'b0, "R2 irq low below");
    setCount(64'h8000_0000_0000_0000);
    busRead(12'h02C, 32'h5, "R2 at 2^63");
    irqSettled(1'b1, "R2 irq at boundary");

    // R9 disabled means no status
    busWrite(12'h02C, 32'h0);
    busRead(12'h02C, 32'h0, "R9 disabled status");
    irqSettled(1'b0, "R9 disabled irq");

    // R4 relative view
    setCount(64'd1000);
    busWrite(12'h028, 32'hFFFF_FFF6);
    busRead(12'h020, 32'd990, "R4 negative rel lo");
    busRead(12'h024, 32'h0, "R4 negative rel hi");
    busWrite(12'h02C, 32'h1);
    busRead(12'h02C, 32'h5, "R4 past due");
    busWrite(12'h028, 32'd50);
    busRead(12'h028, 32'd50, "R4 rel readback");
    busRead(12'h020, 32'd1050, "R4 cmp lo");
    busRead(12'h02C, 32'h1, "R4 not due");
    setCount(64'd1040);
    busRead(12'h028, 32'd10, "R4 rel shrinks");
    setCount(64'h1_0000_0005);
    busWrite(12'h028, 32'hFFFF_FFF6);
    busRead(12'h024, 32'h0, "R4 borrow hi");
    busRead(12'h020, 32'hFFFF_FFFB, "R4 borrow lo");
    busRead(12'h028, 32'hFFFF_FFF6, "R4 rel negative read");
    busWrite(12'h02C, 32'h0);

    // R6 / R7 / R8 / R9 auto-reload
    setCount(64'd100);
    busWrite(12'h048, 32'd10);
    busRead(12'h048, 32'd10, "R6 reload");
    busWrite(12'h04C, 32'h1);
    busRead(12'h040, 32'h0, "R6 no arm while disabled");
    busRead(12'h02C, 32'h0, "R9 selected but disabled");
    busRead(12'h04C, 32'h1, "R8 sel readback");
    busWrite(12'h02C, 32'h1);
    busRead(12'h040, 32'd110, "R6 arm on enable");
    busRead(12'h044, 32'h0, "R6 arm hi");
    busWrite(12'h020, 32'h0);
    busWrite(12'h024, 32'h0);
    busRead(12'h02C, 32'h1, "R9 compare ignored");
    irqSettled(1'b0, "R9 compare ignored irq");
    setCount(64'd110);
    busRead(12'h04C, 32'h3, "R7 flag set");
    busRead(12'h040, 32'd120, "R7 target reloaded");
    busRead(12'h02C, 32'h5, "R9 status follows flag");
    irqSettled(1'b1, "R7 irq from flag");
    busWrite(12'h04C, 32'h3);
    busRead(12'h04C, 32'h3, "R8 write one keeps");
    busWrite(12'h04C, 32'h1);
    busRead(12'h04C, 32'h1, "R8 write zero clears");
    busRead(12'h040, 32'd120, "R8 no rearm");
    irqSettled(1'b0, "R8 irq cleared");
    busWrite(12'h04C, 32'h0);
    busRead(12'h02C, 32'h5, "R9 compare back");
    setCount(64'd200);
    busWrite(12'h04C, 32'h1);
    busRead(12'h040, 32'd210, "R6 arm on select");
    busRead(12'h02C, 32'h1, "R9 flag clear after arm");

    repeat (3) @(negedge clk);
    if (sbQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard: %0d items left", sbQ.size());
    end
    done = 1'b1;
    finishRun();
  end
endmodule